// File: doc/BRIEF.md
# Battery Protection Fault Controller

This block supervises the two high-side switches of a single-cell lithium pack: one that lets charge current in and one that lets load current out. It receives already debounced comparator levels: cell overvoltage, cell below the charge re-enable level, cell undervoltage, charge overcurrent, discharge overcurrent, short circuit, a small-discharge indication, and pack-terminal levels. It also receives a periodic timebase tick. Each fault must persist for its own number of ticks before it is accepted. An accepted fault latches internally and raises a sticky flag. The fault is then held until its own release condition is met, and the block combines every held fault with two host enable bits to form the switch controls.

Release does not run off a timer. An overvoltage is released when the cell falls to the re-enable level, and it is bypassed while a small discharge is seen. An undervoltage is released only by charger presence. A charge overcurrent is released by the pack terminal falling under a pull-down test current. A discharge overcurrent or a short circuit is released by the pack terminal rising under a pull-up test current. The block asks for these test currents itself. An accepted undervoltage also puts the block to sleep. A wake input or a charger brings it back, and leaving sleep sets both enable bits.

Top module: `batt_guard_top`

## Requirements
- R1: After synchronous reset both switch controls are on, all flags are 0, both enable bits are 1, and sleep and both test-current requests are off.
- R2: A fault is accepted only after its condition has been high on DELAY consecutive ticks. The delay counter returns to zero whenever the condition drops, and cycles without a tick do not advance it.
- R3: An accepted overvoltage turns the charge control off and sets the overvoltage flag, while the discharge control stays on. The charge control is on again while the small-discharge input is high, and the fault is released when the below-re-enable input is high.
- R4: An accepted undervoltage turns both controls off, sets the undervoltage flag and enters sleep. The fault is released only by the charger input, which also leaves sleep. A wake input ends sleep without releasing the fault.
- R5: An accepted charge overcurrent turns both controls off, sets the charge-overcurrent flag and requests the pull-down test current. It is released only when the pack-low input is high.
- R6: An accepted discharge overcurrent turns only the discharge control off, sets the discharge-overcurrent flag and requests the pull-up test current. It is released only when the pack-high input is high, and pack-low has no effect on it.
- R7: An accepted short circuit, which has its own shorter delay, has the same effect and the same release as R6.
- R8: A charge-enable bit of 0 holds the charge control off, and a discharge-enable bit of 0 holds the discharge control off. A host write loads both bits.
- R9: Flags are on `flags` with bit 3 overvoltage, bit 2 undervoltage, bit 1 charge overcurrent and bit 0 discharge overcurrent. A host write keeps a flag where `wr_keep` has a 1 and clears it where `wr_keep` has a 0. Flags never clear without a write, and clearing a flag while its fault is still held leaves the controls as they are.
- R10: When a fault is accepted in the same cycle as a host write that clears its flag, the flag ends up set.
- R11: Every transition from sleep to active sets both enable bits to 1, and this overrides a host write in that cycle.
- R12: `stat_chg` and `stat_dsg` show the charge and discharge controls as they were one cycle earlier.
- R13: While asleep, no fault delay advances, so no fault can be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| ov_hi | input | 1 | Cell above overvoltage level |
| below_ce | input | 1 | Cell below charge re-enable level |
| uv_lo | input | 1 | Cell below undervoltage level |
| chg_oc | input | 1 | Charge-direction overcurrent |
| dsg_oc | input | 1 | Discharge-direction overcurrent |
| short_ckt | input | 1 | Short circuit on sense node |
| dsg_small | input | 1 | Discharge of at least the early-release amount |
| pack_lo | input | 1 | Pack terminal below supply minus test threshold |
| pack_hi | input | 1 | Pack terminal above supply minus test threshold |
| charger | input | 1 | Pack terminal above supply (charger present) |
| wake | input | 1 | External wake request (power switch or bus activity) |
| wr_en | input | 1 | Host write strobe |
| wr_keep | input | 4 | Per-flag keep mask for the write (0 clears) |
| wr_chg_en | input | 1 | Charge-enable value for the write |
| wr_dsg_en | input | 1 | Discharge-enable value for the write |
| chg_on | output | 1 | Charge switch control, 1 = on |
| dsg_on | output | 1 | Discharge switch control, 1 = on |
| flags | output | 4 | Sticky fault flags |
| chg_en | output | 1 | Charge-enable bit |
| dsg_en | output | 1 | Discharge-enable bit |
| pull_up | output | 1 | Pull-up test current request |
| pull_down | output | 1 | Pull-down test current request |
| sleep_req | output | 1 | Sleep state / request |
| stat_chg | output | 1 | Registered mirror of charge control |
| stat_dsg | output | 1 | Registered mirror of discharge control |

## Verification
The collision that matters is a host write clearing a flag in the same cycle as a new acceptance of the same fault. The bench holds a short circuit until its last qualifying tick and, on exactly that cycle, strobes a write with an all-zero keep mask. It then expects the discharge flag set, the discharge control off and the pull-up request active. A second pairing is a wake in the same cycle as a host enable write. The bench leaves sleep with both enables written to 0 and expects both bits at 1 after the wake.

// File: rtl/batt_guard_pkg.sv
`timescale 1ns/1ps
package batt_guard_pkg;

    localparam int unsigned NUM_FAULTS = 5;

    // Index of each fault delay counter
    typedef enum logic [2:0] {
        FT_OV  = 3'd0,
        FT_UV  = 3'd1,
        FT_COC = 3'd2,
        FT_DOC = 3'd3,
        FT_SC  = 3'd4
    } fault_e;

    // Sticky flags and held faults share one layout (ov is the MSB)
    typedef struct packed {
        logic ov;
        logic uv;
        logic chg_oc;
        logic dsg_oc;
    } flags_t;

    typedef flags_t latch_t;

    function automatic int unsigned cnt_width(int unsigned delay);
        return (delay < 2) ? 1 : $clog2(delay);
    endfunction

    // Host write keeps or clears, newly accepted faults always win
    function automatic flags_t merge_flags(flags_t cur, flags_t keep,
                                           logic wr, flags_t set_now);
        logic [3:0] base;
        base = wr ? (cur & keep) : cur;
        return flags_t'(base | set_now);
    endfunction

endpackage

// File: rtl/bg_qual_timer.sv
`timescale 1ns/1ps
module bg_qual_timer
    import batt_guard_pkg::*;
#(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic expire
);
    localparam int unsigned W = cnt_width(DELAY);
    localparam logic [W-1:0] LAST = W'(DELAY - 1);

    logic [W-1:0] cnt_q;

    always_comb expire = cond && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
        !cond |=> (cnt_q == '0)) else $error("delay counter kept running"); // R2
    AST_TMR_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cond && !tick) |=> $stable(cnt_q)) else $error("counter moved without tick"); // R2
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST) else $error("counter beyond delay"); // R2

endmodule

// File: rtl/bg_fault_state.sv
`timescale 1ns/1ps
module bg_fault_state
    import batt_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_FAULTS-1:0] expire,
    input  logic                  below_ce,
    input  logic                  charger,
    input  logic                  pack_lo,
    input  logic                  pack_hi,
    input  logic                  wake,
    input  logic                  wr_en,
    input  flags_t                wr_keep,
    input  logic                  wr_chg_en,
    input  logic                  wr_dsg_en,
    output latch_t                lat_q,
    output flags_t                flags_q,
    output logic                  asleep_q,
    output logic                  chg_en_q,
    output logic                  dsg_en_q
);
    flags_t     set_now;
    logic       leaving;
    logic [3:0] flags_vec;

    always_comb begin
        set_now.ov     = expire[FT_OV];
        set_now.uv     = expire[FT_UV];
        set_now.chg_oc = expire[FT_COC];
        set_now.dsg_oc = expire[FT_DOC] | expire[FT_SC];
        leaving        = asleep_q && !expire[FT_UV] && (wake || charger);
        flags_vec      = flags_q;
    end

    // Held faults: acceptance has priority over release
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            lat_q.ov     <= set_now.ov     | (lat_q.ov     & !below_ce);
            lat_q.uv     <= set_now.uv     | (lat_q.uv     & !charger);
            lat_q.chg_oc <= set_now.chg_oc | (lat_q.chg_oc & !pack_lo);
            lat_q.dsg_oc <= set_now.dsg_oc | (lat_q.dsg_oc & !pack_hi);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= merge_flags(flags_q, wr_keep, wr_en, set_now);
    end

    always_ff @(posedge clk) begin
        if (rst)                 asleep_q <= 1'b0;
        else if (expire[FT_UV])  asleep_q <= 1'b1;
        else if (leaving)        asleep_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || leaving) begin
            chg_en_q <= 1'b1;
            dsg_en_q <= 1'b1;
        end else if (wr_en) begin
            chg_en_q <= wr_chg_en;
            dsg_en_q <= wr_dsg_en;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((flags_vec & $past(flags_vec)) == $past(flags_vec)))
        else $error("flag cleared without write"); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set_now.dsg_oc |=> flags_q.dsg_oc) else $error("accepted fault lost its flag"); // R10
    AST_UV_SLEEPS: assert property (@(posedge clk) disable iff (rst)
        expire[FT_UV] |=> (asleep_q && flags_q.uv)) else $error("undervoltage did not sleep"); // R4
    AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep_q) |-> (chg_en_q && dsg_en_q)) else $error("wake left an enable at 0"); // R11

endmodule

// File: rtl/bg_switch_ctrl.sv
`timescale 1ns/1ps
module bg_switch_ctrl
    import batt_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  latch_t lat,
    input  logic   dsg_small,
    input  logic   asleep,
    input  logic   chg_en,
    input  logic   dsg_en,
    output logic   chg_on,
    output logic   dsg_on,
    output logic   pull_up,
    output logic   pull_down,
    output logic   stat_chg,
    output logic   stat_dsg
);
    logic chg_block;
    logic dsg_block;

    always_comb begin
        chg_block = (lat.ov & !dsg_small) | lat.uv | lat.chg_oc | !chg_en | asleep;
        dsg_block = lat.uv | lat.chg_oc | lat.dsg_oc | !dsg_en | asleep;
        chg_on    = !chg_block;
        dsg_on    = !dsg_block;
        pull_down = lat.chg_oc;
        pull_up   = lat.dsg_oc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_chg <= 1'b1;
            stat_dsg <= 1'b1;
        end else begin
            stat_chg <= chg_on;
            stat_dsg <= dsg_on;
        end
    end

endmodule

// File: rtl/batt_guard_top.sv
`timescale 1ns/1ps
module batt_guard_top
    import batt_guard_pkg::*;
#(
    parameter int unsigned OV_TICKS = 20000,
    parameter int unsigned UV_TICKS = 2000,
    parameter int unsigned OC_TICKS = 200,
    parameter int unsigned SC_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ov_hi,
    input  logic       below_ce,
    input  logic       uv_lo,
    input  logic       chg_oc,
    input  logic       dsg_oc,
    input  logic       short_ckt,
    input  logic       dsg_small,
    input  logic       pack_lo,
    input  logic       pack_hi,
    input  logic       charger,
    input  logic       wake,
    input  logic       wr_en,
    input  logic [3:0] wr_keep,
    input  logic       wr_chg_en,
    input  logic       wr_dsg_en,
    output logic       chg_on,
    output logic       dsg_on,
    output logic [3:0] flags,
    output logic       chg_en,
    output logic       dsg_en,
    output logic       pull_up,
    output logic       pull_down,
    output logic       sleep_req,
    output logic       stat_chg,
    output logic       stat_dsg
);
    localparam int unsigned DLY_TAB [NUM_FAULTS] =
        '{OV_TICKS, UV_TICKS, OC_TICKS, OC_TICKS, SC_TICKS};

    logic [NUM_FAULTS-1:0] raw_cond;
    logic [NUM_FAULTS-1:0] cond_vec;
    logic [NUM_FAULTS-1:0] expire;
    latch_t                lat;
    flags_t                flags_s;
    logic                  asleep;

    always_comb begin
        raw_cond[FT_OV]  = ov_hi;
        raw_cond[FT_UV]  = uv_lo;
        raw_cond[FT_COC] = chg_oc;
        raw_cond[FT_DOC] = dsg_oc;
        raw_cond[FT_SC]  = short_ckt;
        cond_vec         = raw_cond & {NUM_FAULTS{!asleep}};
    end

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_timer
        bg_qual_timer #(.DELAY(DLY_TAB[g])) i_timer (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .cond   (cond_vec[g]),
            .expire (expire[g])
        );
    end

    bg_fault_state i_state (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .below_ce  (below_ce),
        .charger   (charger),
        .pack_lo   (pack_lo),
        .pack_hi   (pack_hi),
        .wake      (wake),
        .wr_en     (wr_en),
        .wr_keep   (flags_t'(wr_keep)),
        .wr_chg_en (wr_chg_en),
        .wr_dsg_en (wr_dsg_en),
        .lat_q     (lat),
        .flags_q   (flags_s),
        .asleep_q  (asleep),
        .chg_en_q  (chg_en),
        .dsg_en_q  (dsg_en)
    );

    bg_switch_ctrl i_switch (
        .clk       (clk),
        .rst       (rst),
        .lat       (lat),
        .dsg_small (dsg_small),
        .asleep    (asleep),
        .chg_en    (chg_en),
        .dsg_en    (dsg_en),
        .chg_on    (chg_on),
        .dsg_on    (dsg_on),
        .pull_up   (pull_up),
        .pull_down (pull_down),
        .stat_chg  (stat_chg),
        .stat_dsg  (stat_dsg)
    );

    always_comb begin
        flags     = flags_s;
        sleep_req = asleep;
    end

    AST_SLEEP_BOTH_OFF: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (!chg_on && !dsg_on)) else $error("switch on while asleep"); // R4
    AST_PULLDOWN_BOTH_OFF: assert property (@(posedge clk) disable iff (rst)
        pull_down |-> (!chg_on && !dsg_on)) else $error("switch on during charge overcurrent"); // R5
    AST_PULLUP_DSG_OFF: assert property (@(posedge clk) disable iff (rst)
        pull_up |-> !dsg_on) else $error("discharge on during discharge fault"); // R6
    AST_EN_GATES_CHG: assert property (@(posedge clk) disable iff (rst)
        !chg_en |-> !chg_on) else $error("charge on with enable at 0"); // R8
    AST_ASLEEP_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (expire == '0)) else $error("fault accepted while asleep"); // R13

endmodule

// File: tb/test_batt_guard_top.sv
`timescale 1ns/1ps
module test_batt_guard_top;

    localparam int unsigned OVT = 8;
    localparam int unsigned UVT = 6;
    localparam int unsigned OCT = 4;
    localparam int unsigned SCT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic ov_hi = 0, below_ce = 0, uv_lo = 0, chg_oc = 0, dsg_oc = 0, short_ckt = 0;
    logic dsg_small = 0, pack_lo = 0, pack_hi = 0, charger = 0, wake = 0;
    logic wr_en = 0;
    logic [3:0] wr_keep = 4'hF;
    logic wr_chg_en = 1, wr_dsg_en = 1;
    logic chg_on, dsg_on, chg_en, dsg_en, pull_up, pull_down, sleep_req, stat_chg, stat_dsg;
    logic [3:0] flags;

    always #2.5 clk = ~clk;

    batt_guard_top #(.OV_TICKS(OVT), .UV_TICKS(UVT), .OC_TICKS(OCT), .SC_TICKS(SCT))
    i_batt_guard_top (
        .clk(clk), .rst(rst), .tick(tick), .ov_hi(ov_hi), .below_ce(below_ce),
        .uv_lo(uv_lo), .chg_oc(chg_oc), .dsg_oc(dsg_oc), .short_ckt(short_ckt),
        .dsg_small(dsg_small), .pack_lo(pack_lo), .pack_hi(pack_hi), .charger(charger),
        .wake(wake), .wr_en(wr_en), .wr_keep(wr_keep), .wr_chg_en(wr_chg_en),
        .wr_dsg_en(wr_dsg_en), .chg_on(chg_on), .dsg_on(dsg_on), .flags(flags),
        .chg_en(chg_en), .dsg_en(dsg_en), .pull_up(pull_up), .pull_down(pull_down),
        .sleep_req(sleep_req), .stat_chg(stat_chg), .stat_dsg(stat_dsg)
    );

    typedef struct {
        string       tag;
        logic [12:0] exp;
        logic [12:0] mask;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [12:0] ALL = 13'h1FFF;
    localparam logic [12:0] NOSTAT = 13'h07FF;

    // Layout: stat_chg, stat_dsg, chg_on, dsg_on, flags[3:0], pull_up, pull_down, sleep, chg_en, dsg_en
    function automatic logic [12:0] mk(logic c, logic d, logic [3:0] f, logic pu, logic pd,
                                       logic s, logic ce, logic de);
        return {c, d, c, d, f, pu, pd, s, ce, de};
    endfunction

    wire [12:0] obs = {stat_chg, stat_dsg, chg_on, dsg_on, flags, pull_up, pull_down,
                       sleep_req, chg_en, dsg_en};
    wire [12:0] NORM = mk(1, 1, 4'h0, 0, 0, 0, 1, 1);

    // Driver side: expectation for the state seen just after the next rising edge
    task automatic put(string tag, logic [12:0] exp, logic [12:0] mask);
        item_t it;
        it.tag = tag; it.exp = exp; it.mask = mask;
        q.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares queued expectations one time unit after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if ((obs & it.mask) != (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b (mask %b)", it.tag, obs, it.exp, it.mask);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;
        idle(1);
        put("R1 reset state", NORM, ALL);
        idle(1);

        // R2 restart, then R3 acceptance on the last tick
        ov_hi = 1; idle(5);
        ov_hi = 0; idle(1);
        ov_hi = 1; idle(6);
        put("R2 counter restarted, not yet accepted", NORM, ALL);
        idle(1);
        put("R3 overvoltage accepted", mk(0, 1, 4'h8, 0, 0, 0, 1, 1), NOSTAT);
        idle(1);
        put("R3 R12 mirror follows charge off", mk(0, 1, 4'h8, 0, 0, 0, 1, 1), ALL);
        idle(1);
        dsg_small = 1;
        put("R3 early release on discharge", mk(1, 1, 4'h8, 0, 0, 0, 1, 1), ALL);
        idle(1);
        dsg_small = 0;
        put("R3 held again without discharge", mk(0, 1, 4'h8, 0, 0, 0, 1, 1), ALL);
        idle(1);
        ov_hi = 0; below_ce = 1;
        put("R3 release at re-enable level", mk(1, 1, 4'h8, 0, 0, 0, 1, 1), NOSTAT);
        idle(1);
        below_ce = 0;
        put("R9 flag stays without write", mk(1, 1, 4'h8, 0, 0, 0, 1, 1), ALL);
        idle(1);
        wr_en = 1; wr_keep = 4'b0111;
        put("R9 write clears ov flag", NORM, ALL);
        idle(1);
        wr_en = 0; wr_keep = 4'hF;

        // R5 charge overcurrent
        chg_oc = 1; idle(3);
        put("R5 charge overcurrent accepted", mk(0, 0, 4'h2, 0, 1, 0, 1, 1), NOSTAT);
        idle(1);
        chg_oc = 0;
        put("R5 held after condition drops", mk(0, 0, 4'h2, 0, 1, 0, 1, 1), ALL);
        idle(1);
        wr_en = 1; wr_keep = 4'b1101;
        put("R9 clear while held keeps controls off", mk(0, 0, 4'h0, 0, 1, 0, 1, 1), ALL);
        idle(1);
        wr_en = 0; wr_keep = 4'hF;
        pack_lo = 1;
        put("R5 release on pack low", NORM, NOSTAT);
        idle(1);
        pack_lo = 0;
        put("R5 R12 recovered", NORM, ALL);
        idle(1);

        // R6 discharge overcurrent
        dsg_oc = 1; idle(3);
        put("R6 discharge overcurrent accepted", mk(1, 0, 4'h1, 1, 0, 0, 1, 1), NOSTAT);
        idle(1);
        dsg_oc = 0; pack_lo = 1;
        put("R6 pack low has no effect", mk(1, 0, 4'h1, 1, 0, 0, 1, 1), ALL);
        idle(1);
        pack_lo = 0; pack_hi = 1;
        put("R6 release on pack high", mk(1, 1, 4'h1, 0, 0, 0, 1, 1), NOSTAT);
        idle(1);
        pack_hi = 0; wr_en = 1; wr_keep = 4'b1110;
        put("R6 flag cleared", NORM, ALL);
        idle(1);
        wr_en = 0; wr_keep = 4'hF;

        // R7 short circuit
        short_ckt = 1;
        put("R7 one tick is not enough", NORM, ALL);
        idle(1);
        put("R7 short circuit accepted", mk(1, 0, 4'h1, 1, 0, 0, 1, 1), NOSTAT);
        idle(1);
        short_ckt = 0; pack_hi = 1;
        put("R7 release on pack high", mk(1, 1, 4'h1, 0, 0, 0, 1, 1), NOSTAT);
        idle(1);
        pack_hi = 0; wr_en = 1; wr_keep = 4'b1110;
        put("R7 flag cleared", NORM, ALL);
        idle(1);
        wr_en = 0; wr_keep = 4'hF;

        // R10 acceptance and clearing write in one cycle
        short_ckt = 1; idle(1);
        wr_en = 1; wr_keep = 4'b0000;
        put("R10 acceptance beats clearing write", mk(1, 0, 4'h1, 1, 0, 0, 1, 1), NOSTAT);
        idle(1);
        wr_en = 0; wr_keep = 4'hF; short_ckt = 0; pack_hi = 1; idle(1);
        pack_hi = 0; wr_en = 1; wr_keep = 4'b1110; idle(1);
        wr_en = 0; wr_keep = 4'hF; idle(1);
        put("R10 recovered", NORM, ALL);
        idle(1);

        // R8 host enables
        wr_en = 1; wr_chg_en = 0; wr_dsg_en = 1;
        put("R8 charge enable 0", mk(0, 1, 4'h0, 0, 0, 0, 0, 1), NOSTAT);
        idle(1);
        wr_en = 0;
        put("R8 charge enable 0 steady", mk(0, 1, 4'h0, 0, 0, 0, 0, 1), ALL);
        idle(1);
        wr_en = 1; wr_chg_en = 1; wr_dsg_en = 0;
        put("R8 discharge enable 0", mk(1, 0, 4'h0, 0, 0, 0, 1, 0), NOSTAT);
        idle(1);
        wr_en = 0;
        put("R8 discharge enable 0 steady", mk(1, 0, 4'h0, 0, 0, 0, 1, 0), ALL);
        idle(1);
        wr_en = 1; wr_chg_en = 0; wr_dsg_en = 0; idle(1);
        wr_en = 0; wr_chg_en = 1; wr_dsg_en = 1; idle(1);

        // R4 undervoltage and sleep
        uv_lo = 1; idle(5);
        put("R4 undervoltage sleeps", mk(0, 0, 4'h4, 0, 0, 1, 0, 0), NOSTAT);
        idle(1);
        uv_lo = 0;
        put("R4 asleep steady", mk(0, 0, 4'h4, 0, 0, 1, 0, 0), ALL);
        idle(1);
        ov_hi = 1; idle(12);
        put("R13 no acceptance while asleep", mk(0, 0, 4'h4, 0, 0, 1, 0, 0), ALL);
        idle(1);
        ov_hi = 0;
        wake = 1; wr_en = 1; wr_chg_en = 0; wr_dsg_en = 0;
        put("R11 wake forces enables over write", mk(0, 0, 4'h4, 0, 0, 0, 1, 1), ALL);
        idle(1);
        wake = 0; wr_en = 0; wr_chg_en = 1; wr_dsg_en = 1;
        put("R4 fault held without charger", mk(0, 0, 4'h4, 0, 0, 0, 1, 1), ALL);
        idle(1);
        charger = 1;
        put("R4 charger releases", mk(1, 1, 4'h4, 0, 0, 0, 1, 1), NOSTAT);
        idle(1);
        charger = 0; wr_en = 1; wr_keep = 4'b1011;
        put("R4 flag cleared", NORM, ALL);
        idle(1);
        wr_en = 0; wr_keep = 4'hF;

        // R2 no ticks, no progress
        tick = 0; chg_oc = 1; idle(10);
        put("R2 condition without ticks", NORM, ALL);
        idle(1);
        chg_oc = 0; tick = 1;
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule